// File: doc/BRIEF.md
# RS485 Transceiver Direction Controller

This block drives the direction pin of a half-duplex RS485 transceiver from the state of a serial transmitter. The pin goes to its active level as soon as the transmitter reports that it is busy. Once the last stop bit has left the line, the pin stays active for a programmable number of bit times and is then released. No lead time before sending is provided. The pin polarity can be selected, so transceivers with either enable sense can be used.

A 12-bit configuration word sets the behaviour. When hardware direction control is not fully enabled, the pin simply follows a software-owned RTS bit from the modem-control logic. The transmitter supplies a busy flag, which is high from the first start bit until the shift register and FIFO are both empty after the final stop bit. It also supplies a one-cycle strobe once per bit time.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: Configuration word fields: bit 0 is the automatic-direction enable, bit 1 hands the pin to hardware, bit 2 inverts the pin, and bits 11:8 give the post-transmit hold in bit times (0 to 15). Hardware direction control is in effect only when bits 0 and 1 are both 1.
- R2: Outside hardware direction control, `dir_pin` equals `sw_rts` in the same cycle, whatever `tx_busy` and `bit_tick` do.
- R3: Under hardware direction control, `sw_rts` has no effect on `dir_pin`.
- R4: Under hardware direction control, `dir_pin` is at its active level from the first clock edge at which `tx_busy` is sampled high, with no lead delay.
- R5: With a hold of N greater than 0, after the edge at which `tx_busy` is first sampled low, the pin stays active until the edge that samples the N-th `bit_tick` pulse. It becomes inactive at that edge. A tick sampled at that first low edge is not counted.
- R6: With a hold of 0, the pin becomes inactive at the edge at which `tx_busy` is first sampled low.
- R7: If `tx_busy` rises again during the hold, the hold is cancelled and the pin stays active. The next hold after transmission ends again counts the full N ticks.
- R8: Under hardware direction control, the active level is 1 when bit 2 is 0 and 0 when bit 2 is 1. The inactive level is the opposite.
- R9: During synchronous active-low reset the controller is idle, so `dir_pin` shows the inactive level under hardware control and `sw_rts` otherwise.
- R10: Leaving hardware direction control abandons any send or hold in progress. When hardware control is enabled again, the controller starts idle, with the pin inactive until `tx_busy` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 12 | Configuration word (fields in R1) |
| tx_busy | input | 1 | Transmitter has a character in flight or queued |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| sw_rts | input | 1 | Software RTS bit from modem control |
| dir_pin | output | 1 | Transceiver direction pin |

## Verification
A wrong controller state shows on `dir_pin` within one clock. A stuck send or hold state keeps the pin active past the expected release edge. A lost state releases it before the hold count is reached. A miscounted hold register moves the release edge by a whole tick spacing, so the bench checks the pin both after every tick and between ticks. It does this for every hold value and both polarities, which locates an off-by-one to the exact tick.

// File: rtl/rs485_dir_pkg.sv
// Package: shared field positions, widths and state encoding for the
// RS485 direction controller. Assumes a 12-bit configuration word.
package rs485_dir_pkg;
    localparam int CFG_W    = 12;
    localparam int HOLD_W   = 4;
    localparam int EN_BIT   = 0;
    localparam int PIN_BIT  = 1;
    localparam int POL_BIT  = 2;
    localparam int HOLD_LSB = 8;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_SEND = 2'd1,
        DIR_HOLD = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic              auto_en;
        logic              hw_pin;
        logic              invert;
        logic [HOLD_W-1:0] hold;
    } dir_cfg_t;
endpackage

// File: rtl/rs485_cfg_decode.sv
// Module: splits the configuration word into its fields and derives the
// hardware-control qualifier. Assumes the positions in rs485_dir_pkg.
module rs485_cfg_decode
    import rs485_dir_pkg::*;
#(
    parameter int CW = CFG_W,
    parameter int HW = HOLD_W
) (
    input  logic [CW-1:0] cfg_word,
    output dir_cfg_t      fields,
    output logic          hw_mode,
    output logic          hold_zero
);
    localparam int HOLD_MSB = HOLD_LSB + HW - 1;

    // Field extraction
    always_comb begin
        fields.auto_en = cfg_word[EN_BIT];
        fields.hw_pin  = cfg_word[PIN_BIT];
        fields.invert  = cfg_word[POL_BIT];
        fields.hold    = cfg_word[HOLD_MSB:HOLD_LSB];
    end

    // Hardware owns the pin only with both enable bits set
    assign hw_mode   = fields.auto_en & fields.hw_pin;
    assign hold_zero = (fields.hold == '0);

    logic unused_bits;
    assign unused_bits = ^{cfg_word[CW-1:HOLD_MSB+1], cfg_word[HOLD_LSB-1:POL_BIT+1]};
endmodule

// File: rtl/rs485_hold_timer.sv
// Module: counts bit-time strobes during the post-transmit hold.
// Assumes load is only pulsed with a non-zero value; counter clears when
// not running so a cancelled hold never leaks into the next one.
module rs485_hold_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         done,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    // Remaining-tick counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (!run)
            count <= '0;
        else if (tick && count != '0)
            count <= count - ONE;
    end

    // Final tick of the hold window
    assign done = run & tick & (count == ONE);
endmodule

// File: rtl/rs485_dir_fsm.sv
// Module: idle / send / hold sequencer for the direction pin.
// Assumes tx_busy stays high from first start bit to final stop bit.
module rs485_dir_fsm
    import rs485_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_mode,
    input  logic       tx_busy,
    input  logic       hold_zero,
    input  logic       timer_done,
    output dir_state_e state,
    output logic       load_hold,
    output logic       run_hold,
    output logic       active
);
    dir_state_e state_nx;

    // Next-state selection
    always_comb begin
        state_nx = state;
        if (!hw_mode) begin
            state_nx = DIR_IDLE;
        end else begin
            case (state)
                DIR_IDLE: if (tx_busy) state_nx = DIR_SEND;
                DIR_SEND: if (!tx_busy) state_nx = hold_zero ? DIR_IDLE : DIR_HOLD;
                DIR_HOLD: begin
                    if (tx_busy)         state_nx = DIR_SEND;
                    else if (timer_done) state_nx = DIR_IDLE;
                end
                default:  state_nx = DIR_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= DIR_IDLE;
        else        state <= state_nx;
    end

    // Timer controls and line-active indication
    assign load_hold = hw_mode & (state == DIR_SEND) & ~tx_busy & ~hold_zero;
    assign run_hold  = (state == DIR_HOLD) & ~tx_busy;
    assign active    = (state != DIR_IDLE);
endmodule

// File: rtl/rs485_dir_ctrl.sv
// Top: RS485 direction controller. Combines field decode, sequencer,
// hold timer and the output select between hardware and software RTS.
// Assumes bit_tick is a single-cycle strobe in the clk domain.
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int CW = CFG_W,
    parameter int HW = HOLD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_word,
    input  logic          tx_busy,
    input  logic          bit_tick,
    input  logic          sw_rts,
    output logic          dir_pin
);
    dir_cfg_t   fields;
    logic       hw_mode;
    logic       hold_zero;
    dir_state_e fsm_state;
    logic       load_hold;
    logic       run_hold;
    logic       line_active;
    logic       timer_done;
    logic [HW-1:0] hold_cnt;

    rs485_cfg_decode #(.CW(CW), .HW(HW)) u_dec (
        .cfg_word  (cfg_word),
        .fields    (fields),
        .hw_mode   (hw_mode),
        .hold_zero (hold_zero)
    );

    rs485_dir_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_mode    (hw_mode),
        .tx_busy    (tx_busy),
        .hold_zero  (hold_zero),
        .timer_done (timer_done),
        .state      (fsm_state),
        .load_hold  (load_hold),
        .run_hold   (run_hold),
        .active     (line_active)
    );

    rs485_hold_timer #(.W(HW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_hold),
        .load_val (fields.hold),
        .run      (run_hold),
        .tick     (bit_tick),
        .done     (timer_done),
        .count    (hold_cnt)
    );

    // Output select: hardware level with polarity, or software bit
    always_comb begin
        if (hw_mode) dir_pin = line_active ^ fields.invert;
        else         dir_pin = sw_rts;
    end
endmodule

// File: rtl/rs485_dir_chk.sv
// Checker: temporal properties of the direction controller, bound to top.
module rs485_dir_chk
    import rs485_dir_pkg::*;
#(
    parameter int CW = CFG_W,
    parameter int HW = HOLD_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cfg_word,
    input logic          tx_busy,
    input logic          bit_tick,
    input logic          dir_pin,
    input logic          hw_mode,
    input dir_state_e    state,
    input logic [HW-1:0] cnt
);
    AST_BUSY_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode && tx_busy |=> (!hw_mode || dir_pin != cfg_word[POL_BIT])); // R4
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode && state == DIR_SEND && !tx_busy && cfg_word[HOLD_LSB+HW-1:HOLD_LSB] == '0
        |=> state == DIR_IDLE); // R6
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode && state == DIR_HOLD && !tx_busy && !bit_tick |=> state == DIR_HOLD); // R5
    AST_HOLD_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state == DIR_HOLD |-> cnt != '0); // R5
    AST_RESTART_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode && state == DIR_HOLD && tx_busy |=> state == DIR_SEND); // R7
    AST_SW_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_mode |=> state == DIR_IDLE); // R10
endmodule

bind rs485_dir_ctrl rs485_dir_chk #(.CW(CW), .HW(HW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .tx_busy  (tx_busy),
    .bit_tick (bit_tick),
    .dir_pin  (dir_pin),
    .hw_mode  (hw_mode),
    .state    (fsm_state),
    .cnt      (hold_cnt)
);

// File: tb/rs485_dir_ctrl_tb.sv
// Bench: sweeps every hold value and both polarities, plus software mode,
// restart, reset and mode-exit cases. Drives and samples on falling edges.
module rs485_dir_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_word = '0;
    logic        tx_busy = 1'b0;
    logic        bit_tick = 1'b0;
    logic        sw_rts = 1'b0;
    logic        dir_pin;
    int          n_run = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    rs485_dir_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .tx_busy(tx_busy), .bit_tick(bit_tick), .sw_rts(sw_rts),
        .dir_pin(dir_pin)
    );

    function automatic logic [11:0] mk_cfg(input logic en, input logic pin,
                                           input logic inv, input int hold);
        return {hold[3:0], 5'b0, inv, pin, en};
    endfunction

    task automatic chk(input string req, input logic exp);
        n_run++;
        if (dir_pin !== exp) begin
            n_fail++;
            $display("FAIL %s: dir_pin=%b expected %b (t=%0t)", req, dir_pin, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected <= 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state under hardware control, busy high, both polarities
        cfg_word = mk_cfg(1, 1, 0, 3); tx_busy = 1'b1;
        cycles(2);
        chk("R9 reset inactive pol0", 1'b0);
        cfg_word = mk_cfg(1, 1, 1, 3);
        cycles(1);
        chk("R9 reset inactive pol1", 1'b1);
        cfg_word = '0; sw_rts = 1'b1;
        cycles(1);
        chk("R9 reset sw passthrough", 1'b1);
        tx_busy = 1'b0;
        rst_n = 1'b1;
        cycles(2);

        // R1 R2: software mode for each non-hardware enable combination
        for (int m = 0; m < 3; m++) begin
            for (int b = 0; b < 4; b++) begin
                cfg_word = mk_cfg(m[0], m[1], b[0], 7);
                tx_busy = b[1];
                sw_rts = b[0] ^ m[0];
                bit_tick = b[0];
                #1;
                chk("R2 sw follow same cycle", b[0] ^ m[0]);
                cycles(1);
                chk("R1 R2 sw follow after edge", b[0] ^ m[0]);
            end
        end
        bit_tick = 1'b0; tx_busy = 1'b0;

        // R4 R5 R6 R8 R3: every hold value, both polarities
        for (int inv = 0; inv < 2; inv++) begin
            for (int h = 0; h < 16; h++) begin
                logic act;
                act = ~inv[0];
                cfg_word = '0; cycles(1);
                cfg_word = mk_cfg(1, 1, inv[0], h);
                sw_rts = act;
                cycles(2);
                chk("R8 idle inactive", ~act);
                tx_busy = 1'b1;
                cycles(1);
                chk("R4 active at first busy edge", act);
                sw_rts = ~act;
                cycles(2);
                chk("R3 R8 active ignores sw", act);
                tx_busy = 1'b0;
                bit_tick = 1'b1;   // tick at first low edge must not count
                cycles(1);
                bit_tick = 1'b0;
                if (h == 0) begin
                    chk("R6 zero hold release", ~act);
                end else begin
                    chk("R5 hold starts active", act);
                    for (int k = 1; k <= h; k++) begin
                        sw_rts = k[0];
                        cycles(1);
                        chk("R5 R3 between ticks", act);
                        bit_tick = 1'b1;
                        cycles(1);
                        bit_tick = 1'b0;
                        if (k < h) chk("R5 before last tick", act);
                        else       chk("R5 release on last tick", ~act);
                    end
                end
                cycles(2);
                chk("R5 stays released", ~act);
            end
        end

        // R7: restart during hold, then full hold counted again
        cfg_word = mk_cfg(1, 1, 0, 5);
        tx_busy = 1'b1; cycles(2);
        tx_busy = 1'b0; cycles(1);
        for (int k = 0; k < 3; k++) begin
            bit_tick = 1'b1; cycles(1); bit_tick = 1'b0; cycles(1);
        end
        chk("R7 mid hold active", 1'b1);
        tx_busy = 1'b1; cycles(1);
        chk("R7 restart keeps active", 1'b1);
        cycles(2);
        tx_busy = 1'b0; cycles(1);
        for (int k = 1; k <= 5; k++) begin
            bit_tick = 1'b1; cycles(1); bit_tick = 1'b0;
            if (k < 5) chk("R7 full hold recounted", 1'b1);
            else       chk("R7 release after full hold", 1'b0);
            cycles(1);
        end

        // R10: leaving hardware mode mid-hold, then re-entry starts idle
        cfg_word = mk_cfg(1, 1, 0, 9);
        tx_busy = 1'b1; cycles(2);
        tx_busy = 1'b0; cycles(1);
        bit_tick = 1'b1; cycles(1); bit_tick = 1'b0;
        chk("R10 in hold", 1'b1);
        sw_rts = 1'b0;
        cfg_word = mk_cfg(1, 0, 0, 9);
        cycles(1);
        chk("R10 sw owns pin", 1'b0);
        cfg_word = mk_cfg(1, 1, 0, 9);
        #1;
        chk("R10 re-entry idle", 1'b0);
        cycles(3);
        chk("R10 re-entry stays idle", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule